// File: doc/BRIEF.md
# Dual Timebase Counter Unit with Lockable Prescalers

This block keeps two free-running 16-bit timebase counters for a timer subsystem. Counter A runs from the system clock. A coarse divider (slow, fast or extended) feeds a fine prescaler that divides again by 1, 2, 4 or 8. Counter B counts events taken from an external pin. In pin-clock mode the pin is synchronized and its edges are counted, either rising edges only or both edges. In gated mode the synchronized pin enables an internal divide-by-8 tick. Counter B has its own fine prescaler.

One control word is written through a single write strobe and can be read back at all times. The two fine-prescaler codes are locked after their first write, unless an unlock bit is already set in the stored word. The mode bit is locked after its first write, with no way to unlock it. A halt bit freezes both counters and every divider behind them, and a stop flag reports the halted state. The pin is never used as a clock: every edge becomes a one-cycle enable in the system clock domain.

Top module: `tbase_unit`

## Requirements
- R1: After reset both counters read 0, `stopped` is 0, and the control word reads 0x400 (only the mode bit is set).
- R2: A 2-bit fine code (bits [2:1] for counter A, bits [4:3] for counter B) divides the incoming ticks: 00 by 1, 01 by 2, 10 by 4, 11 by 8.
- R3: With bit 6 (extended) clear, counter A's coarse divider is 32 when bit 5 (fast select) is 0 and 4 when bit 5 is 1.
- R4: With bit 6 set, the coarse divider is 16 and bit 5 has no effect.
- R5: The first write after reset loads each fine code. A later write to a code is ignored while the stored unlock bit (bit 9) is clear. The unlock value that applies is the one held before that write.
- R6: While the stored unlock bit is 1, the fine codes take each new write.
- R7: The mode bit (bit 10) resets to 1, takes exactly one write after reset, and reads back through `cfg_rd`.
- R8: While the halt bit (bit 0) is set, `stopped` reads 1 and both counters hold their values, even if the pin toggles. When halt is cleared, `stopped` returns to 0 and counting resumes.
- R9: With bit 7 (gate mode) clear and bit 8 (both edges) clear, counter B counts each rising edge of `ext_pin` after a two-flop synchronizer.
- R10: With bit 7 clear and bit 8 set, counter B counts both rising and falling edges of the synchronized pin.
- R11: With bit 7 set, counter B advances once every 8 system clocks while the synchronized pin is high, and does not advance while the pin is low.
- R12: Each counter wraps from 0xFFFF to 0.
- R13: A counter only ever steps by exactly one (modulo 2^16) from one clock to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 11 | Control word to write |
| cfg_rd | output | 11 | Stored control word |
| ext_pin | input | 1 | External event pin, asynchronous |
| stopped | output | 1 | Stop flag, 1 while halted |
| cnt_a | output | 16 | Counter A value |
| cnt_b | output | 16 | Counter B value |

## Verification
Counter A's rate is measured over windows that are whole multiples of the expected period, so the result does not depend on divider phase. The windows cover each fine code, both standard coarse settings, and the extended setting with fast select both 0 and 1, which shows the divider choices are distinct and that fast select is ignored in extended mode. Counter B is driven with slow pulse trains in rising-only and both-edge modes, which separates the two edge counts. It is also driven with the pin held high and held low in gated mode, which separates gating from plain clocking. A pin toggling every cycle drives counter B across 0xFFFF. Write sequences that retry a locked code before and after the unlock bit is stored show the one-write delay of the unlock.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef struct packed {
        logic       mode;      // bit 10
        logic       unlock;    // bit 9
        logic       b_both;    // bit 8
        logic       b_gate;    // bit 7
        logic       ext_en;    // bit 6
        logic       fast_sel;  // bit 5
        logic [1:0] b_code;    // bits 4:3
        logic [1:0] a_code;    // bits 2:1
        logic       halt;      // bit 0
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam cfg_t CFG_RST = cfg_t'(11'h400);

    function automatic logic [2:0] fine_limit(input logic [1:0] code);
        case (code)
            2'b00:   fine_limit = 3'd0;
            2'b01:   fine_limit = 3'd1;
            2'b10:   fine_limit = 3'd3;
            default: fine_limit = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/tbase_cfg.sv
module tbase_cfg
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic             a_lock,
    output logic             b_lock
);

    typedef struct packed {
        cfg_t c;
        logic a_lk;
        logic b_lk;
        logic m_lk;
    } st_t;

    st_t  st_d, st_q;
    cfg_t wr_c;

    assign wr_c = cfg_t'(wr_data);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.c.halt     = wr_c.halt;
            st_d.c.fast_sel = wr_c.fast_sel;
            st_d.c.ext_en   = wr_c.ext_en;
            st_d.c.b_gate   = wr_c.b_gate;
            st_d.c.b_both   = wr_c.b_both;
            st_d.c.unlock   = wr_c.unlock;
            if (!st_q.a_lk || st_q.c.unlock) begin
                st_d.c.a_code = wr_c.a_code;
            end
            if (!st_q.b_lk || st_q.c.unlock) begin
                st_d.c.b_code = wr_c.b_code;
            end
            if (!st_q.m_lk) begin
                st_d.c.mode = wr_c.mode;
            end
            st_d.a_lk = 1'b1;
            st_d.b_lk = 1'b1;
            st_d.m_lk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{c: CFG_RST, a_lk: 1'b0, b_lk: 1'b0, m_lk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg    = st_q.c;
    assign a_lock = st_q.a_lk;
    assign b_lock = st_q.b_lk;

endmodule

// File: rtl/tbase_src_a.sv
module tbase_src_a #(
    parameter int SLOW_DIV = 32,
    parameter int FAST_DIV = 4,
    parameter int EXT_DIV  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast_sel,
    input  logic ext_en,
    output logic tick
);

    localparam int MAX_AB = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int MAX_D  = (MAX_AB > EXT_DIV) ? MAX_AB : EXT_DIV;
    localparam int CW     = $clog2(MAX_D);

    typedef struct packed {
        logic [CW-1:0] div;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] lim;
    logic          wrap;

    always_comb begin
        if (ext_en) begin
            lim = CW'(EXT_DIV - 1);
        end else if (fast_sel) begin
            lim = CW'(FAST_DIV - 1);
        end else begin
            lim = CW'(SLOW_DIV - 1);
        end
    end

    assign wrap = (st_q.div >= lim);

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.div = wrap ? '0 : st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = run && wrap;

endmodule

// File: rtl/tbase_src_b.sv
module tbase_src_b #(
    parameter int GATE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pin,
    input  logic gate_mode,
    input  logic both_edges,
    output logic tick
);

    localparam int GW = $clog2(GATE_DIV);

    typedef struct packed {
        logic [1:0]    sy;
        logic          prev;
        logic [GW-1:0] gd;
    } st_t;

    st_t  st_d, st_q;
    logic s_pin;
    logic rise;
    logic fall;
    logic gate_tick;

    assign s_pin     = st_q.sy[1];
    assign rise      = s_pin && !st_q.prev;
    assign fall      = !s_pin && st_q.prev;
    assign gate_tick = (st_q.gd == GW'(GATE_DIV - 1));

    always_comb begin
        st_d      = st_q;
        st_d.sy   = {st_q.sy[0], pin};
        st_d.prev = s_pin;
        if (run) begin
            st_d.gd = gate_tick ? '0 : st_q.gd + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (gate_mode) begin
            tick = gate_tick && s_pin;
        end else begin
            tick = rise || (both_edges && fall);
        end
    end

endmodule

// File: rtl/tbase_fine.sv
module tbase_fine
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [2:0]       pre;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t        st_d, st_q;
    logic [2:0] lim;

    assign lim = fine_limit(code);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.pre >= lim) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
    import tbase_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SLOW_DIV = 32,
    parameter int FAST_DIV = 4,
    parameter int EXT_DIV  = 16,
    parameter int GATE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_rd,
    input  logic             ext_pin,
    output logic             stopped,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b
);

    cfg_t cfg;
    logic a_lock;
    logic b_lock;
    logic run;
    logic tick_a;
    logic tick_b;

    tbase_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .a_lock  (a_lock),
        .b_lock  (b_lock)
    );

    assign run = !cfg.halt;

    tbase_src_a #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV),
        .EXT_DIV  (EXT_DIV)
    ) u_src_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .fast_sel (cfg.fast_sel),
        .ext_en   (cfg.ext_en),
        .tick     (tick_a)
    );

    tbase_src_b #(
        .GATE_DIV (GATE_DIV)
    ) u_src_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .pin        (ext_pin),
        .gate_mode  (cfg.b_gate),
        .both_edges (cfg.b_both),
        .tick       (tick_b)
    );

    tbase_fine #(.CNT_W(CNT_W)) u_fine_a (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_a),
        .code  (cfg.a_code),
        .cnt   (cnt_a)
    );

    tbase_fine #(.CNT_W(CNT_W)) u_fine_b (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_b),
        .code  (cfg.b_code),
        .cnt   (cnt_b)
    );

    assign cfg_rd  = cfg;
    assign stopped = cfg.halt;

endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
    parameter int CNT_W = 16,
    parameter int CW    = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CW-1:0]    cfg_rd,
    input logic             stopped,
    input logic             a_lock,
    input logic             b_lock,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b
);

    a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> ($stable(cnt_a) && $stable(cnt_b)));

    a_r5_code_a_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (a_lock && !cfg_rd[9]) |=> $stable(cfg_rd[2:1]));

    a_r5_code_b_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (b_lock && !cfg_rd[9]) |=> $stable(cfg_rd[4:3]));

    a_r7_mode_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd[10] |=> !cfg_rd[10]);

    a_r13_step_a: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_a) |-> (cnt_a == CNT_W'($past(cnt_a) + 1'b1)));

    a_r13_step_b: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_b) |-> (cnt_b == CNT_W'($past(cnt_b) + 1'b1)));

endmodule

bind tbase_unit tbase_chk #(.CNT_W(CNT_W), .CW(tbase_pkg::CFG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_rd  (cfg_rd),
    .stopped (stopped),
    .a_lock  (a_lock),
    .b_lock  (b_lock),
    .cnt_a   (cnt_a),
    .cnt_b   (cnt_b)
);

// File: tb/test_tbase_unit.sv
`timescale 1ns/1ps
module test_tbase_unit;
    import tbase_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [CFG_W-1:0] wr_data = '0;
    logic [CFG_W-1:0] cfg_rd;
    logic             ext_pin = 1'b0;
    logic             stopped;
    logic [15:0]      cnt_a;
    logic [15:0]      cnt_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    cfg_t sh;

    always #4 clk = ~clk;

    tbase_unit i_tbase_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_rd  (cfg_rd),
        .ext_pin (ext_pin),
        .stopped (stopped),
        .cnt_a   (cnt_a),
        .cnt_b   (cnt_b)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input cfg_t c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = c;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rate_a(input int period, input int mult, input string tag);
        logic [15:0] s0;
        cyc(2 * period + 2);
        s0 = cnt_a;
        cyc(period * mult);
        check(32'(cnt_a - s0), 32'(mult), tag);
    endtask

    task automatic t_reset();
        check(32'(cnt_a), 0, "R1 cnt_a");
        check(32'(cnt_b), 0, "R1 cnt_b");
        check(32'(stopped), 0, "R1 stopped");
        check(32'(cfg_rd), 32'h400, "R1 cfg_rd");
    endtask

    task automatic t_lock();
        sh = CFG_RST;
        sh.a_code = 2'b01; sh.fast_sel = 1'b1; sh.mode = 1'b0;
        wr(sh);
        check(32'(cfg_rd[2:1]), 1, "R5 first code write");
        check(32'(cfg_rd[10]), 0, "R7 mode first write");
        rate_a(8, 8, "R2 R3 fast /4 code01");
        sh.a_code = 2'b11; sh.b_code = 2'b10; sh.mode = 1'b1;
        wr(sh);
        check(32'(cfg_rd[2:1]), 1, "R5 code a locked");
        check(32'(cfg_rd[4:3]), 0, "R5 code b locked");
        check(32'(cfg_rd[10]), 0, "R7 mode locked");
        rate_a(8, 8, "R5 rate unchanged");
        sh.unlock = 1'b1; sh.a_code = 2'b00;
        wr(sh);
        check(32'(cfg_rd[2:1]), 1, "R5 unlock not yet stored");
        wr(sh);
        check(32'(cfg_rd[2:1]), 0, "R6 rewrite after unlock");
        check(32'(cfg_rd[4:3]), 2, "R6 code b rewrite");
        sh.b_code = 2'b00;
        wr(sh);
        rate_a(4, 16, "R2 code00");
        sh.a_code = 2'b10; wr(sh);
        rate_a(16, 8, "R2 code10");
        sh.a_code = 2'b11; wr(sh);
        rate_a(32, 8, "R2 code11");
        sh.a_code = 2'b00; sh.fast_sel = 1'b0; wr(sh);
        rate_a(32, 8, "R3 slow /32");
        sh.ext_en = 1'b1; wr(sh);
        rate_a(16, 8, "R4 ext fast0");
        sh.fast_sel = 1'b1; wr(sh);
        rate_a(16, 8, "R4 ext fast1");
        sh.ext_en = 1'b0; wr(sh);
    endtask

    task automatic t_halt();
        logic [15:0] a0, b0;
        sh.halt = 1'b1; wr(sh);
        check(32'(stopped), 1, "R8 stop flag set");
        cyc(2);
        a0 = cnt_a; b0 = cnt_b;
        repeat (5) begin
            ext_pin = 1'b1; cyc(3);
            ext_pin = 1'b0; cyc(3);
        end
        cyc(60);
        check(32'(cnt_a), 32'(a0), "R8 cnt_a frozen");
        check(32'(cnt_b), 32'(b0), "R8 cnt_b frozen");
        sh.halt = 1'b0; wr(sh);
        check(32'(stopped), 0, "R8 stop flag clear");
        rate_a(4, 16, "R8 resume");
    endtask

    task automatic t_pins();
        logic [15:0] b0;
        cyc(6);
        b0 = cnt_b;
        repeat (10) begin
            ext_pin = 1'b1; cyc(3);
            ext_pin = 1'b0; cyc(3);
        end
        cyc(6);
        check(32'(cnt_b - b0), 10, "R9 rising edges");
        sh.b_both = 1'b1; wr(sh);
        cyc(6);
        b0 = cnt_b;
        repeat (10) begin
            ext_pin = 1'b1; cyc(3);
            ext_pin = 1'b0; cyc(3);
        end
        cyc(6);
        check(32'(cnt_b - b0), 20, "R10 both edges");
        sh.b_gate = 1'b1; wr(sh);
        ext_pin = 1'b1;
        cyc(16);
        b0 = cnt_b;
        cyc(64);
        check(32'(cnt_b - b0), 8, "R11 gate open");
        ext_pin = 1'b0;
        cyc(6);
        b0 = cnt_b;
        cyc(64);
        check(32'(cnt_b - b0), 0, "R11 gate closed");
    endtask

    task automatic t_wrap();
        logic [15:0] b0;
        int n;
        sh.b_gate = 1'b0; sh.b_both = 1'b1; wr(sh);
        repeat (6) begin
            @(negedge clk); ext_pin = ~ext_pin;
        end
        b0 = cnt_b;
        n  = 65536 - int'(b0) + 7;
        repeat (n) begin
            @(negedge clk); ext_pin = ~ext_pin;
        end
        check(32'(cnt_b), 7, "R12 cnt_b wrapped");
        ext_pin = 1'b0;
        cyc(6);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_lock();
        t_halt();
        t_pins();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule